// File: doc/BRIEF.md
# Binary-synchronous frame receiver

This block sits behind a character-aligned serial front end and turns a stream of received octets into the payload of byte-oriented synchronous frames. It waits for the two-character sync pair. It reads the opening control character or characters to find the frame class: header plus text, plain text, or transparent text. It then passes only payload characters downstream. Each character carries a tag that says which part of the frame it came from. The sync characters, the framing control characters and the escape characters added by stuffing are all dropped.

When the frame closes, the block checks the trailing block-check characters. In 8-bit mode it uses a reflected 16-bit cyclic code. In 7-bit mode it uses an XOR longitudinal character together with odd parity on every character. One cycle after the last check character it raises exactly one status pulse. A bad escape sequence inside transparent text aborts the frame with its own status pulse. In both cases the receiver goes back to hunting for sync. The mode input selects which check applies and how characters are compared.

Top module: `bsc_rx`

## Requirements
- R1: A frame opens only after the first sync code (default 0x32) is followed by the second sync code (default 0x16) on the next valid character. A second sync code alone, or a pair split by another character, delivers no data and no status.
- R2: After the sync pair, further sync codes before the opening control character are dropped and do not enter the block check.
- R3: An opening start-of-header (0x01) starts a header section. Its characters come out with out_tag = 1. A start-of-text (0x02) then switches to text, and that start-of-text is not delivered but does enter the block check.
- R4: An opening start-of-text starts plain text (out_tag = 2). An end-of-text (0x03) ends the text and is not delivered. That end-of-text and all header and text characters enter the block check. The opening control character does not.
- R5: The escape code (0x10) followed by start-of-text opens transparent text (out_tag = 3). Inside transparent text, escape-escape delivers one 0x10 data character, a lone end-of-text is delivered as data, and escape followed by end-of-text ends the text. Only the end-of-text of that closing pair enters the block check.
- R6: In transparent text, an escape followed by any other character gives a one-cycle frame_err pulse. The frame is dropped and the receiver hunts for sync again, so characters after it are not delivered.
- R7: In 8-bit mode (lrc_mode = 0) the block check is CRC-16 with reflected polynomial 0xA001 and initial value 0. It is sent low byte first. frame_ok pulses if the residue over the covered characters and both check bytes is zero; otherwise crc_err pulses.
- R8: In 7-bit mode (lrc_mode = 1), every character from the opening control character onward carries odd parity in bit 7. Codes are compared on bits 6:0, and data comes out with bit 7 cleared. One check character holds the XOR of bits 6:0 of the covered characters. A parity fault gives parity_err, which takes priority over crc_err on an XOR mismatch.
- R9: Exactly one of frame_ok, crc_err or parity_err pulses for one cycle. It is visible in the cycle after the last check character is accepted. No data is delivered in a cycle that carries a status pulse.
- R10: While rst_n is low, and after reset until a frame arrives, out_valid and all four status outputs are 0.
- R11: A character is taken only when in_valid is high. Each delivered character appears with out_valid high for one cycle, in the cycle after it was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrc_mode | input | 1 | 1: 7-bit characters with parity and XOR check; 0: 8-bit with CRC-16 |
| in_valid | input | 1 | in_byte holds a received character |
| in_byte | input | 8 | Received character |
| out_valid | output | 1 | Payload character present |
| out_byte | output | 8 | Payload character |
| out_tag | output | 2 | 1 header, 2 plain text, 3 transparent text |
| frame_ok | output | 1 | Pulse: frame ended with a good check |
| crc_err | output | 1 | Pulse: block check mismatch |
| parity_err | output | 1 | Pulse: character parity fault in 7-bit mode |
| frame_err | output | 1 | Pulse: invalid escape sequence in transparent text |

## Verification
Four properties hold on every cycle, and the assertions check them:
- at most one status output is high, and each status lasts only one cycle;
- no payload is delivered together with a status pulse;
- every delivered character carries a nonzero tag and was accepted one cycle earlier;
- in 7-bit mode, bit 7 of delivered data is clear.

Only the bench scenarios can show that the right characters come out in the right order with the right tags. That includes the removal of stuffing, the extra sync characters, a lone end-of-text inside transparent text, and the rejection of a false sync. The same applies to the choice between good, check-error and parity-error outcomes, which depends on the arithmetic of the whole frame.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_SYN1,
        ST_OPEN,
        ST_ODLE,
        ST_HDR,
        ST_TXT,
        ST_TTX,
        ST_TDLE,
        ST_BCC1,
        ST_BCC2
    } rx_state_e;

    typedef enum logic [1:0] {
        TAG_NONE = 2'd0,
        TAG_HDR  = 2'd1,
        TAG_TXT  = 2'd2,
        TAG_TTX  = 2'd3
    } data_tag_e;

    // positions of the control codes in the classifier hit vector
    localparam int K_SYN1 = 0;
    localparam int K_SYN2 = 1;
    localparam int K_SOH  = 2;
    localparam int K_STX  = 3;
    localparam int K_ETX  = 4;
    localparam int K_DLE  = 5;
    localparam int K_NUM  = 6;

endpackage

// File: rtl/bsc_char_class.sv
module bsc_char_class #(
    parameter int CHAR_W = 8,
    parameter int N      = 6,
    parameter logic [N*CHAR_W-1:0] CODES = '0
) (
    input  logic [CHAR_W-1:0] ch,
    input  logic              lrc_mode,
    output logic [N-1:0]      hit
);
    localparam logic [CHAR_W-1:0] MASK_NARROW = {1'b0, {(CHAR_W-1){1'b1}}};

    logic [CHAR_W-1:0] mask;
    assign mask = lrc_mode ? MASK_NARROW : '1;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = ((ch ^ CODES[g*CHAR_W +: CHAR_W]) & mask) == '0;
    end
endmodule

// File: rtl/bsc_bcc_accum.sv
module bsc_bcc_accum #(
    parameter int CHAR_W = 8,
    parameter int CRC_W  = 16,
    parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic              par_chk,
    input  logic              lrc_mode,
    input  logic [CHAR_W-1:0] in_char,
    output logic [CRC_W-1:0]  acc_nxt,
    output logic              par_bad_nxt
);
    localparam int LRC_W = CHAR_W - 1;

    logic [CRC_W-1:0] acc_q, acc_d;
    logic             pb_q, pb_d;
    logic             fb;

    always_comb begin
        acc_d = clr ? '0 : acc_q;
        pb_d  = clr ? 1'b0 : pb_q;
        fb    = 1'b0;
        if (upd) begin
            if (lrc_mode) begin
                acc_d = acc_d ^ CRC_W'(in_char[LRC_W-1:0]);
            end else begin
                for (int i = 0; i < CHAR_W; i++) begin
                    fb    = acc_d[0] ^ in_char[i];
                    acc_d = acc_d >> 1;
                    if (fb) acc_d = acc_d ^ CRC_POLY;
                end
            end
        end
        if (par_chk && lrc_mode && !(^in_char)) pb_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            pb_q  <= 1'b0;
        end else begin
            acc_q <= acc_d;
            pb_q  <= pb_d;
        end
    end

    assign acc_nxt     = acc_d;
    assign par_bad_nxt = pb_d;
endmodule

// File: rtl/bsc_rx.sv
module bsc_rx
    import bsc_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int CRC_W  = 16,
    parameter logic [CRC_W-1:0]  CRC_POLY  = 16'hA001,
    parameter logic [CHAR_W-1:0] SYN1_CODE = 8'h32,
    parameter logic [CHAR_W-1:0] SYN2_CODE = 8'h16,
    parameter logic [CHAR_W-1:0] SOH_CODE  = 8'h01,
    parameter logic [CHAR_W-1:0] STX_CODE  = 8'h02,
    parameter logic [CHAR_W-1:0] ETX_CODE  = 8'h03,
    parameter logic [CHAR_W-1:0] DLE_CODE  = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lrc_mode,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_byte,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_byte,
    output logic [1:0]        out_tag,
    output logic              frame_ok,
    output logic              crc_err,
    output logic              parity_err,
    output logic              frame_err
);
    localparam logic [K_NUM*CHAR_W-1:0] CODE_VEC =
        {DLE_CODE, ETX_CODE, STX_CODE, SOH_CODE, SYN2_CODE, SYN1_CODE};

    typedef struct packed {
        rx_state_e         st;
        logic              ov;
        logic [CHAR_W-1:0] ob;
        logic [1:0]        otag;
        logic              ok;
        logic              ce;
        logic              pe;
        logic              fe;
    } rx_regs_t;

    rx_regs_t r_q, r_d;

    logic [K_NUM-1:0]  hit;
    logic              acc_clr, acc_upd, par_upd;
    logic [CRC_W-1:0]  acc_nxt;
    logic              par_bad_nxt;
    logic [CHAR_W-1:0] dval;
    logic              finish;

    bsc_char_class #(.CHAR_W(CHAR_W), .N(K_NUM), .CODES(CODE_VEC)) u_class (
        .ch(in_byte), .lrc_mode(lrc_mode), .hit(hit)
    );

    bsc_bcc_accum #(.CHAR_W(CHAR_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .upd(acc_upd), .par_chk(par_upd),
        .lrc_mode(lrc_mode), .in_char(in_byte), .acc_nxt(acc_nxt),
        .par_bad_nxt(par_bad_nxt)
    );

    assign dval = lrc_mode ? {1'b0, in_byte[CHAR_W-2:0]} : in_byte;

    always_comb begin
        r_d     = r_q;
        r_d.ov  = 1'b0;
        r_d.ok  = 1'b0;
        r_d.ce  = 1'b0;
        r_d.pe  = 1'b0;
        r_d.fe  = 1'b0;
        acc_clr = 1'b0;
        acc_upd = 1'b0;
        par_upd = 1'b0;
        finish  = 1'b0;
        if (in_valid) begin
            unique case (r_q.st)
                ST_HUNT: if (hit[K_SYN1]) r_d.st = ST_SYN1;
                ST_SYN1: begin
                    if (hit[K_SYN2])      r_d.st = ST_OPEN;
                    else if (!hit[K_SYN1]) r_d.st = ST_HUNT;
                end
                ST_OPEN: begin
                    acc_clr = 1'b1;
                    if (hit[K_SYN1] || hit[K_SYN2]) begin
                        r_d.st = ST_OPEN;
                    end else begin
                        par_upd = 1'b1;
                        if (hit[K_SOH])      r_d.st = ST_HDR;
                        else if (hit[K_STX]) r_d.st = ST_TXT;
                        else if (hit[K_DLE]) r_d.st = ST_ODLE;
                        else                 r_d.st = ST_HUNT;
                    end
                end
                ST_ODLE: begin
                    par_upd = 1'b1;
                    r_d.st  = hit[K_STX] ? ST_TTX : ST_HUNT;
                end
                ST_HDR: begin
                    par_upd = 1'b1;
                    acc_upd = 1'b1;
                    if (hit[K_STX]) begin
                        r_d.st = ST_TXT;
                    end else begin
                        r_d.ov = 1'b1; r_d.ob = dval; r_d.otag = TAG_HDR;
                    end
                end
                ST_TXT: begin
                    par_upd = 1'b1;
                    acc_upd = 1'b1;
                    if (hit[K_ETX]) begin
                        r_d.st = ST_BCC1;
                    end else begin
                        r_d.ov = 1'b1; r_d.ob = dval; r_d.otag = TAG_TXT;
                    end
                end
                ST_TTX: begin
                    par_upd = 1'b1;
                    if (hit[K_DLE]) begin
                        r_d.st = ST_TDLE;
                    end else begin
                        acc_upd = 1'b1;
                        r_d.ov = 1'b1; r_d.ob = dval; r_d.otag = TAG_TTX;
                    end
                end
                ST_TDLE: begin
                    par_upd = 1'b1;
                    if (hit[K_DLE]) begin
                        acc_upd = 1'b1;
                        r_d.st  = ST_TTX;
                        r_d.ov = 1'b1; r_d.ob = dval; r_d.otag = TAG_TTX;
                    end else if (hit[K_ETX]) begin
                        acc_upd = 1'b1;
                        r_d.st  = ST_BCC1;
                    end else begin
                        r_d.fe = 1'b1;
                        r_d.st = ST_HUNT;
                    end
                end
                ST_BCC1: begin
                    par_upd = 1'b1;
                    acc_upd = 1'b1;
                    if (lrc_mode) finish = 1'b1;
                    else          r_d.st = ST_BCC2;
                end
                ST_BCC2: begin
                    acc_upd = 1'b1;
                    finish  = 1'b1;
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
        if (finish) begin
            r_d.st = ST_HUNT;
            if (par_bad_nxt)        r_d.pe = 1'b1;
            else if (acc_nxt != '0) r_d.ce = 1'b1;
            else                    r_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_HUNT, default: '0};
        else        r_q <= r_d;
    end

    assign out_valid  = r_q.ov;
    assign out_byte   = r_q.ob;
    assign out_tag    = r_q.otag;
    assign frame_ok   = r_q.ok;
    assign crc_err    = r_q.ce;
    assign parity_err = r_q.pe;
    assign frame_err  = r_q.fe;
endmodule

// File: rtl/bsc_rx_chk.sv
module bsc_rx_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lrc_mode,
    input logic              in_valid,
    input logic              out_valid,
    input logic [CHAR_W-1:0] out_byte,
    input logic [1:0]        out_tag,
    input logic              frame_ok,
    input logic              crc_err,
    input logic              parity_err,
    input logic              frame_err
);
    logic any_stat;
    assign any_stat = frame_ok | crc_err | parity_err | frame_err;

    // R9
    status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_ok, crc_err, parity_err, frame_err}));

    // R9
    status_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stat |=> !any_stat);

    // R9
    status_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stat |-> !out_valid);

    // R6
    abort_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !out_valid);

    // R11
    out_after_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    // R3
    out_tagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag != 2'd0);

    // R8
    narrow_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(lrc_mode)) |-> out_byte[CHAR_W-1] == 1'b0);
endmodule

bind bsc_rx bsc_rx_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lrc_mode(lrc_mode), .in_valid(in_valid),
    .out_valid(out_valid), .out_byte(out_byte), .out_tag(out_tag),
    .frame_ok(frame_ok), .crc_err(crc_err), .parity_err(parity_err),
    .frame_err(frame_err)
);

// File: tb/bsc_rx_bench.sv
module bsc_rx_bench;
    localparam logic [7:0] C_SYN1 = 8'h32;
    localparam logic [7:0] C_SYN2 = 8'h16;
    localparam logic [7:0] C_SOH  = 8'h01;
    localparam logic [7:0] C_STX  = 8'h02;
    localparam logic [7:0] C_ETX  = 8'h03;
    localparam logic [7:0] C_DLE  = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrc_mode = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_byte;
    logic [1:0] out_tag;
    logic       frame_ok, crc_err, parity_err, frame_err;

    always #10 clk = ~clk;

    bsc_rx u_bsc_rx (
        .clk(clk), .rst_n(rst_n), .lrc_mode(lrc_mode), .in_valid(in_valid),
        .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte),
        .out_tag(out_tag), .frame_ok(frame_ok), .crc_err(crc_err),
        .parity_err(parity_err), .frame_err(frame_err)
    );

    int tests = 0;
    int fails = 0;

    logic [7:0] tx[$];
    logic [7:0] eb[$];
    logic [1:0] et[$];
    logic [7:0] rb[$];
    logic [1:0] rt[$];
    logic [7:0] hdr[$];
    logic [7:0] pl[$];
    logic [15:0] bacc;
    int n_ok, n_ce, n_pe, n_fe;
    logic [3:0] stat_after;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                rb.push_back(out_byte);
                rt.push_back(out_tag);
            end
            if (frame_ok)   n_ok++;
            if (crc_err)    n_ce++;
            if (parity_err) n_pe++;
            if (frame_err)  n_fe++;
        end
    end

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] wp(input logic [7:0] c, input bit m7);
        return m7 ? {~^c[6:0], c[6:0]} : c;
    endfunction

    function automatic logic [7:0] dv(input logic [7:0] c, input bit m7);
        return m7 ? {1'b0, c[6:0]} : c;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] a, input logic [7:0] b);
        logic [15:0] r = a;
        for (int i = 0; i < 8; i++) begin
            logic f = r[0] ^ b[i];
            r = r >> 1;
            if (f) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic cov(input logic [7:0] c, input bit m7);
        if (m7) bacc[6:0] = bacc[6:0] ^ c[6:0];
        else    bacc = crc_step(bacc, c);
    endtask

    task automatic push_data(input logic [7:0] c, input bit m7, input logic [1:0] tg);
        eb.push_back(dv(c, m7));
        et.push_back(tg);
    endtask

    // kind 0: plain text, 1: header + text, 2: transparent text
    task automatic build(input int kind, input bit m7, input int nsyn,
                         input bit bad_bcc, input bit bad_par);
        int ppos = -1;
        logic [7:0] lo, hi, b;
        tx.delete(); eb.delete(); et.delete();
        bacc = 16'h0;
        tx.push_back(C_SYN1);
        tx.push_back(C_SYN2);
        for (int i = 0; i < nsyn; i++) tx.push_back((i % 2) ? C_SYN1 : C_SYN2);
        if (kind == 1) begin
            tx.push_back(wp(C_SOH, m7));
            foreach (hdr[i]) begin
                tx.push_back(wp(hdr[i], m7)); cov(hdr[i], m7); push_data(hdr[i], m7, 2'd1);
            end
            tx.push_back(wp(C_STX, m7)); cov(C_STX, m7);
        end
        if (kind == 0) tx.push_back(wp(C_STX, m7));
        if (kind < 2) begin
            foreach (pl[i]) begin
                if (ppos < 0) ppos = tx.size();
                tx.push_back(wp(pl[i], m7)); cov(pl[i], m7); push_data(pl[i], m7, 2'd2);
            end
            tx.push_back(wp(C_ETX, m7)); cov(C_ETX, m7);
        end else begin
            tx.push_back(wp(C_DLE, m7));
            tx.push_back(wp(C_STX, m7));
            foreach (pl[i]) begin
                if (ppos < 0) ppos = tx.size();
                if (dv(pl[i], m7) == C_DLE) tx.push_back(wp(C_DLE, m7));
                tx.push_back(wp(pl[i], m7)); cov(pl[i], m7); push_data(pl[i], m7, 2'd3);
            end
            tx.push_back(wp(C_DLE, m7));
            tx.push_back(wp(C_ETX, m7)); cov(C_ETX, m7);
        end
        if (m7) begin
            b = {1'b0, bacc[6:0]};
            if (bad_bcc) b[0] = ~b[0];
            tx.push_back(wp(b, 1'b1));
        end else begin
            lo = bacc[7:0]; hi = bacc[15:8];
            if (bad_bcc) lo[0] = ~lo[0];
            tx.push_back(lo); tx.push_back(hi);
        end
        if (bad_par && m7 && ppos >= 0) tx[ppos][7] = ~tx[ppos][7];
    endtask

    task automatic drive(input bit m7);
        rb.delete(); rt.delete();
        n_ok = 0; n_ce = 0; n_pe = 0; n_fe = 0;
        lrc_mode = m7;
        foreach (tx[i]) begin
            int gap = $urandom % 3;
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte  = 8'(($urandom % 2) ? C_SYN1 : $urandom);
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = tx[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        stat_after = {frame_ok, crc_err, parity_err, frame_err};
        repeat (3) @(negedge clk);
    endtask

    // exp_stat: 8 ok, 4 check error, 2 parity error, 1 frame error, 0 none
    task automatic evaluate(input string dreq, input string sreq, input logic [3:0] exp_stat,
                            input bit timed);
        bit good = (rb.size() == eb.size());
        int bad_i = -1;
        if (good) begin
            foreach (eb[i]) if (bad_i < 0 && (rb[i] != eb[i] || rt[i] != et[i])) bad_i = i;
            good = (bad_i < 0);
        end
        if (bad_i >= 0)
            chk(good, dreq, "payload character", int'({rt[bad_i], rb[bad_i]}),
                int'({et[bad_i], eb[bad_i]}));
        else
            chk(good, dreq, "payload count (R11)", rb.size(), eb.size());
        chk({n_ok, n_ce, n_pe, n_fe} == {exp_stat[3] ? 32'd1 : 32'd0, exp_stat[2] ? 32'd1 : 32'd0,
                                         exp_stat[1] ? 32'd1 : 32'd0, exp_stat[0] ? 32'd1 : 32'd0},
            sreq, "status pulses ok/ce/pe/fe", n_ok*1000 + n_ce*100 + n_pe*10 + n_fe,
            (exp_stat[3] ? 1000 : 0) + (exp_stat[2] ? 100 : 0) + (exp_stat[1] ? 10 : 0) +
            (exp_stat[0] ? 1 : 0));
        if (timed)
            chk(stat_after == exp_stat, "R9", "status one cycle after last check char",
                stat_after, exp_stat);
    endtask

    function automatic logic [7:0] rnd_char(input bit m7, input bit no_etx);
        logic [7:0] c;
        do begin
            c = 8'($urandom);
            if (m7) c[7] = 1'b0;
        end while (dv(c, m7) == C_STX || (no_etx && dv(c, m7) == C_ETX));
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0b5c));
        repeat (3) @(negedge clk);
        // R10: outputs idle during reset
        chk({out_valid, frame_ok, crc_err, parity_err, frame_err} == 5'b0, "R10",
            "outputs in reset", {out_valid, frame_ok, crc_err, parity_err, frame_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({out_valid, frame_ok, crc_err, parity_err, frame_err} == 5'b0, "R10",
            "outputs after reset", {out_valid, frame_ok, crc_err, parity_err, frame_err}, 0);

        // R1: second sync code alone, then a pair split by another character
        tx = '{C_SYN2, C_STX, 8'h41, C_ETX, 8'h00, 8'h00,
               C_SYN1, 8'h55, C_SYN2, C_STX, 8'h42, C_ETX, 8'h00, 8'h00};
        eb.delete(); et.delete();
        drive(1'b0);
        evaluate("R1", "R1", 4'b0000, 1'b0);

        // R2 + R4: extra sync codes after the pair, plain text, 8-bit
        hdr.delete(); pl = '{8'h41, C_DLE, 8'h7E, 8'hFF};
        build(0, 1'b0, 3, 1'b0, 1'b0);
        drive(1'b0);
        evaluate("R2", "R7", 4'b1000, 1'b1);

        // R5: stuffed escape and lone end-of-text inside transparent text
        pl = '{C_ETX, C_DLE, C_DLE, 8'h55, C_SYN1, C_STX};
        build(2, 1'b0, 0, 1'b0, 1'b0);
        drive(1'b0);
        evaluate("R5", "R7", 4'b1000, 1'b1);

        // R3: header then text, 7-bit
        hdr = '{8'h31, 8'h45}; pl = '{8'h20, 8'h7F};
        build(1, 1'b1, 0, 1'b0, 1'b0);
        drive(1'b1);
        evaluate("R3", "R8", 4'b1000, 1'b1);

        // R6: escape followed by an ordinary character aborts
        tx = '{C_SYN1, C_SYN2, C_DLE, C_STX, 8'h41, 8'h42, C_DLE, 8'h44, C_STX, 8'h46, C_ETX};
        eb = '{8'h41, 8'h42}; et = '{2'd3, 2'd3};
        drive(1'b0);
        evaluate("R6", "R6", 4'b0001, 1'b0);

        // R8: parity fault outranks a check mismatch
        hdr.delete(); pl = '{8'h11, 8'h22, 8'h33};
        build(0, 1'b1, 0, 1'b1, 1'b1);
        drive(1'b1);
        evaluate("R8", "R8", 4'b0010, 1'b1);

        // R7: corrupted CRC in 8-bit mode
        build(2, 1'b0, 1, 1'b1, 1'b0);
        drive(1'b0);
        evaluate("R5", "R7", 4'b0100, 1'b1);

        // random frames
        for (int n = 0; n < 36; n++) begin
            int kind = $urandom % 3;
            bit m7 = 1'($urandom % 2);
            int r = $urandom % 4;
            int len = 1 + ($urandom % 12);
            bit bb = (r == 1);
            bit bp = (r == 2) && m7;
            logic [3:0] es = bp ? 4'b0010 : (bb ? 4'b0100 : 4'b1000);
            hdr.delete(); pl.delete();
            if (kind == 1) for (int i = 0; i < 1 + ($urandom % 4); i++) hdr.push_back(rnd_char(m7, 1'b0));
            for (int i = 0; i < len; i++) begin
                if (kind == 2) begin
                    logic [7:0] c = 8'($urandom);
                    if (m7) c[7] = 1'b0;
                    if ($urandom % 4 == 0) c = ($urandom % 2) ? C_DLE : C_ETX;
                    pl.push_back(c);
                end else begin
                    pl.push_back(rnd_char(m7, 1'b1));
                end
            end
            build(kind, m7, $urandom % 3, bb, bp);
            drive(m7);
            evaluate(kind == 0 ? "R4" : (kind == 1 ? "R3" : "R5"), m7 ? "R8" : "R7", es, 1'b1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule